// File: doc/BRIEF.md
# Loopback Transmit Byte Capture Buffer

This block keeps the most recent transmit bytes of a packet sent while the controller runs in loopback, so that software can check what went out on the wire. Each byte the transmit path strobes while loopback is enabled goes into a small circular store. When the store is full, each new byte replaces the oldest one. After the packet, the CPU reads one byte register again and again. Each read returns the next retained byte, oldest first, and moves the read position on by one.

A packet-start strobe discards the previous capture and rewinds the read position. Packets shorter than the store depth return their captured bytes first and then zeros. Outside loopback the register reads as zero and the store does not move. The depth and the byte width are parameters; the depth must be a power of two. The storage has no reset and uses one write port and one registered read port, so it can map onto block RAM.

Top module: `lbcap_fifo`

## Requirements
- R1: After the synchronous active-high reset `rd_data` is 0, and enabled reads made before any byte has been captured return 0.
- R2: A byte is captured only in a cycle where `tx_valid` and `lb_en` are both 1. Bytes strobed while `lb_en` is 0 do not change what later reads return.
- R3: When a packet has more than DEPTH bytes, only its last DEPTH bytes are kept. Successive reads return them oldest first.
- R4: A read strobe taken at a clock edge updates `rd_data` at that edge. `rd_data` then holds its value until the next read strobe.
- R5: When a packet has N < DEPTH bytes, reads 0 to N-1 return those bytes in transmit order and reads N to DEPTH-1 return 0.
- R6: After DEPTH enabled reads the read position wraps, and the next read returns the oldest retained byte again.
- R7: A read strobe while `lb_en` is 0 returns 0 and does not advance the read position.
- R8: `pkt_start` empties the capture and resets the read position to the oldest byte. A byte strobed in the same cycle becomes the first byte of the new packet.
- R9: When a read and a capture fall in the same cycle, the read returns the byte chosen by the contents before that capture. Once the store is full, each capture moves the oldest position forward by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lb_en | input | 1 | Loopback mode enabled |
| pkt_start | input | 1 | Start of a new transmitted packet |
| tx_valid | input | 1 | Transmit byte strobe |
| tx_byte | input | DATA_W | Transmitted byte |
| rd_stb | input | 1 | CPU read strobe for the capture register |
| rd_data | output | DATA_W | Byte returned by the last read |

## Verification
A CPU read and a transmit capture can fall in the same cycle. So can a read and a packet start, and in the worst case all three. The bench provokes each case by strobing read, byte and packet-start together: once while the store is full and its oldest position is moving, once while it is partly filled, and once right at a packet boundary. A queue-based model in the bench resolves each such cycle read-first: the read uses the old contents, then the packet start is applied, then the capture. Every clock, the model's expected byte is compared with `rd_data`.

// File: rtl/lbcap_pkg.sv
package lbcap_pkg;
  function automatic int unsigned lbcap_aw(input int unsigned depth);
    return (depth <= 1) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/lbcap_wr_ctrl.sv
module lbcap_wr_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = lbcap_pkg::lbcap_aw(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pkt_start,
  input  logic          wr,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] base,
  output logic [AW:0]   fill
);
  logic [AW-1:0] wp;

  assign wr_addr = pkt_start ? '0 : wp;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      fill <= '0;
      base <= '0;
    end else if (pkt_start) begin
      wp   <= wr ? AW'(1) : '0;
      fill <= wr ? (AW+1)'(1) : '0;
      base <= '0;
    end else if (wr) begin
      wp <= wp + AW'(1);
      if (fill == (AW+1)'(DEPTH)) base <= base + AW'(1);
      else                        fill <= fill + (AW+1)'(1);
    end
  end

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
    fill <= (AW+1)'(DEPTH));

  assert_base_fixed_until_full_R5: assert property (@(posedge clk) disable iff (rst)
    (fill < (AW+1)'(DEPTH)) |-> (base == '0));

  assert_start_empties_R8: assert property (@(posedge clk) disable iff (rst)
    pkt_start |=> (fill <= (AW+1)'(1)) && (base == '0));
endmodule

// File: rtl/lbcap_store.sv
module lbcap_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned AW = lbcap_pkg::lbcap_aw(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lbcap_rd_ctrl.sv
module lbcap_rd_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = lbcap_pkg::lbcap_aw(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lb_en,
  input  logic          pkt_start,
  input  logic          rd_stb,
  input  logic [AW-1:0] base,
  input  logic [AW:0]   fill,
  output logic [AW-1:0] rd_addr,
  output logic          rd_hit
);
  logic [AW-1:0] idx;

  assign rd_addr = base + idx;
  assign rd_hit  = lb_en && ({1'b0, idx} < fill);

  always_ff @(posedge clk) begin
    if (rst || pkt_start) idx <= '0;
    else if (rd_stb && lb_en) idx <= idx + AW'(1);
  end

  assert_idle_read_holds_pos_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !lb_en && !pkt_start) |=> $stable(idx));

  assert_start_rewinds_R8: assert property (@(posedge clk) disable iff (rst)
    pkt_start |=> (idx == '0));
endmodule

// File: rtl/lbcap_fifo.sv
module lbcap_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned AW = lbcap_pkg::lbcap_aw(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lb_en,
  input  logic              pkt_start,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data
);
  logic              wr;
  logic [AW-1:0]     wr_addr;
  logic [AW-1:0]     base;
  logic [AW:0]       fill;
  logic [AW-1:0]     rd_addr;
  logic              rd_hit;
  logic              hit_q;
  logic [DATA_W-1:0] mem_q;

  assign wr = tx_valid && lb_en;

  lbcap_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst(rst), .pkt_start(pkt_start), .wr(wr),
    .wr_addr(wr_addr), .base(base), .fill(fill)
  );

  lbcap_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst(rst), .lb_en(lb_en), .pkt_start(pkt_start),
    .rd_stb(rd_stb), .base(base), .fill(fill),
    .rd_addr(rd_addr), .rd_hit(rd_hit)
  );

  lbcap_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(wr), .waddr(wr_addr), .wdata(tx_byte),
    .re(rd_stb), .raddr(rd_addr), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else if (rd_stb) hit_q <= rd_hit;
  end

  assign rd_data = hit_q ? mem_q : '0;

  assert_off_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !lb_en) |=> (rd_data == '0));

  assert_hold_without_read_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (rd_data == '0));
endmodule

// File: tb/lbcap_fifo_bench.sv
module lbcap_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lb_en = 1'b0;
  logic       pkt_start = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_byte = '0;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  logic [7:0] q[$];
  int idx = 0;
  logic [7:0] exp_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbcap_fifo #(.DATA_W(8), .DEPTH(DEPTH)) u_lbcap_fifo (
    .clk(clk), .rst(rst), .lb_en(lb_en), .pkt_start(pkt_start),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .rd_stb(rd_stb), .rd_data(rd_data)
  );

  // Reference model: read-first, then packet start, then capture.
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      idx = 0;
      exp_data = '0;
    end else begin
      if (rd_stb) begin
        if (lb_en) begin
          exp_data = (idx < q.size()) ? q[idx] : 8'h00;
          idx = (idx + 1) % DEPTH;
        end else begin
          exp_data = 8'h00;
        end
      end
      if (pkt_start) begin
        q.delete();
        idx = 0;
      end
      if (tx_valid && lb_en) begin
        q.push_back(tx_byte);
        if (q.size() > DEPTH) void'(q.pop_front());
      end
    end
  end

  task automatic check_now();
    checks++;
    if (rd_data !== exp_data) begin
      errors++;
      $display("FAIL %s rd_data=%02h expected=%02h at %0t", tag, rd_data, exp_data, $time);
    end
  endtask

  task automatic step(input bit ps, input bit tv, input logic [7:0] b, input bit rd);
    pkt_start = ps; tx_valid = tv; tx_byte = b; rd_stb = rd;
    @(posedge clk);
    @(negedge clk);
    check_now();
    pkt_start = 0; tx_valid = 0; rd_stb = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    if (!done) $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state and reads of an empty capture
    tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now();
    rst = 0;
    lb_en = 1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1);

    // R5: short packet returns bytes then zeros
    tag = "R5";
    step(1, 1, 8'hA0, 0);
    for (int i = 1; i < 5; i++) step(0, 1, 8'(8'hA0 + i), 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1);
    // R6: wrap back to the first byte
    tag = "R6";
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1);

    // R3: long packet keeps the last eight bytes
    tag = "R3";
    step(1, 0, 0, 0);
    for (int i = 0; i < 13; i++) step(0, 1, 8'(8'h10 + i), 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1);
    tag = "R6";
    step(0, 0, 0, 1);

    // R4: hold between sparse reads
    tag = "R4";
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);
      step(0, 0, 0, 1);
    end

    // R2 and R7: loopback off ignores bytes, reads give 0 and keep position
    tag = "R7";
    lb_en = 0;
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
    tag = "R2";
    for (int i = 0; i < 6; i++) step(0, 1, 8'(8'hE0 + i), 0);
    lb_en = 1;
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1);

    // R9: read and capture in the same cycle while full
    tag = "R9";
    for (int i = 0; i < 10; i++) step(0, 1, 8'(8'h50 + i), 1);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1);
    // R9: same cycle while partly filled
    step(1, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 8'(8'h70 + i), 1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1);

    // R8: packet start, capture and read together
    tag = "R8";
    step(0, 0, 0, 1);
    step(1, 1, 8'hC3, 1);
    step(0, 1, 8'hC4, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1);

    // R1: reset mid-stream clears
    tag = "R1";
    rst = 1;
    step(0, 0, 0, 0);
    rst = 0;
    for (int i = 0; i < 2; i++) step(0, 0, 0, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule